// File: doc/BRIEF.md
# Destination-Initiated Handshake Link

This block moves parallel data words from a producing unit to a consuming unit over a four-phase, two-wire asynchronous handshake in which the receiving side opens every transfer. The receiving half raises a request line when it has room for a word. The sending half has already taken a word from its push interface. It sees the request, puts the word on the link bus, and raises a valid line one clock later. The receiving half sees the valid line, captures the bus, presents the word on its pop interface and drops its request. The sending half sees the request fall, drops valid and clears the bus. The link is then back at rest.

Both halves are in the one top module, but they share no state. Each half sees the other only through its link ports and re-times the incoming control line through a two-flop synchronizer. The halves can therefore sit in different clock domains once the top is split. They can also be wired back to back, as the bench does. On each half, a counter watches the wait for the partner to drop its line. If that wait reaches a programmable limit, the half sets a sticky error flag and abandons the transfer.

Top module: `dest_handshake_link`

## Requirements
- R1: While reset is held and right after it: valid low, request low, link bus all zeros, no word on the pop side, both error flags low, and the push side ready.
- R2: The receiving half raises its request only when its pop buffer is empty and it has seen the valid line low. It never requests while an unread word is held.
- R3: The sending half drives a word on the link bus only after it has seen the request high through its synchronizer. The bus holds that word for at least one clock before valid rises and stays stable while valid is high. The bus reads all zeros whenever the sending half is ready for a new push.
- R4: When the receiving half sees valid high, it captures the bus word, shows it on the pop side with the pop-valid output high, and drops its request. Words come out exactly once each, in push order. Pop-valid clears when the consumer pulses the take input.
- R5: After the sending half sees the request fall, it drops valid and becomes ready for the next push.
- R6: If valid has been high for the limit plus one clock and the request has still not fallen, the sending half sets its error flag, drops valid, discards the word and returns to ready.
- R7: If the receiving half has captured a word and valid does not fall within the limit plus one clock, it sets its error flag and returns to idle. The captured word stays available on the pop side.
- R8: After a capture, the request is not raised again until valid has been seen low. A valid line stuck high therefore never yields a second capture.
- R9: Both error flags stay set until reset. Normal transfers continue while a flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| timeoutLimit | input | CNT_W | Wait limit in clocks for both timeout counters (nonzero) |
| pushValid | input | 1 | Producer offers a word |
| pushData | input | DATA_W | Word offered by the producer |
| pushReady | output | 1 | Sending half is idle and accepts a push |
| srcRfdIn | input | 1 | Request line as seen by the sending half |
| srcDvOut | output | 1 | Valid line driven by the sending half |
| srcDataOut | output | DATA_W | Link bus driven by the sending half |
| dstDvIn | input | 1 | Valid line as seen by the receiving half |
| dstDataIn | input | DATA_W | Link bus as seen by the receiving half |
| dstRfdOut | output | 1 | Request line driven by the receiving half |
| popValid | output | 1 | A captured word is waiting |
| popData | output | DATA_W | The captured word |
| popTake | input | 1 | Consumer takes the waiting word |
| srcTimeout | output | 1 | Sticky error flag of the sending half |
| dstTimeout | output | 1 | Sticky error flag of the receiving half |

## Verification
The hardest situations to reach are the ones with a broken partner. When the two halves are wired directly to each other, neither timeout can fire and valid can never stay high after a capture. The bench therefore routes the link through a fault switch. One setting holds the request high at the sending half and hides valid from the receiving half, which starves the sending half. The other setting holds valid high at the receiving half, which forces its timeout and then the stuck-valid case where a second capture must not happen.

// File: rtl/dhl_pkg.sv
package dhl_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE,
    SRC_WAIT_REQ,
    SRC_DRIVE,
    SRC_VALID
  } srcState_e;

  typedef enum logic [1:0] {
    DST_IDLE,
    DST_REQ,
    DST_HOLD
  } dstState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic srcLoad;
    logic srcDrive;
    logic srcClear;
    logic srcWait;
    logic dstCapture;
    logic dstWait;
  } ctrlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic rfdSync;
    logic dvSync;
    logic srcExpired;
    logic dstExpired;
    logic popValid;
  } dpStatus_t;
endpackage

// File: rtl/dhl_datapath.sv
module dhl_datapath
  import dhl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  timeoutLimit,
  input  logic [DATA_W-1:0] pushData,
  input  logic              srcRfdIn,
  input  logic              dstDvIn,
  input  logic [DATA_W-1:0] dstDataIn,
  input  logic              popTake,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  output logic [DATA_W-1:0] srcDataOut,
  output logic [DATA_W-1:0] popData,
  output logic              srcTimeout,
  output logic              dstTimeout
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] rfdPipe;
  logic [LAST:0] dvPipe;
  logic [DATA_W-1:0] srcWord;
  logic [DATA_W-1:0] busQ;
  logic [DATA_W-1:0] popQ;
  logic popValidQ;
  logic [CNT_W-1:0] srcCnt;
  logic [CNT_W-1:0] dstCnt;
  logic srcExp;
  logic dstExp;
  logic srcFlagQ;
  logic dstFlagQ;

  // two-flop (or deeper) synchronizers for the incoming control lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rfdPipe <= '0;
      dvPipe  <= '0;
    end else begin
      rfdPipe <= {rfdPipe[LAST-1:0], srcRfdIn};
      dvPipe  <= {dvPipe[LAST-1:0], dstDvIn};
    end
  end

  // sending half: held word and link bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcWord <= '0;
      busQ    <= '0;
    end else begin
      if (strobe.srcLoad) srcWord <= pushData;
      if (strobe.srcClear) busQ <= '0;
      else if (strobe.srcDrive) busQ <= srcWord;
    end
  end

  // receiving half: pop buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      popQ      <= '0;
      popValidQ <= 1'b0;
    end else if (strobe.dstCapture) begin
      popQ      <= dstDataIn;
      popValidQ <= 1'b1;
    end else if (popTake) begin
      popValidQ <= 1'b0;
    end
  end

  // timeout counters, cleared whenever their side is not waiting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcCnt   <= '0;
      dstCnt   <= '0;
      srcFlagQ <= 1'b0;
      dstFlagQ <= 1'b0;
    end else begin
      srcCnt   <= strobe.srcWait ? srcCnt + 1'b1 : '0;
      dstCnt   <= strobe.dstWait ? dstCnt + 1'b1 : '0;
      srcFlagQ <= srcFlagQ | srcExp;
      dstFlagQ <= dstFlagQ | dstExp;
    end
  end

  assign srcExp = strobe.srcWait && (srcCnt == timeoutLimit);
  assign dstExp = strobe.dstWait && (dstCnt == timeoutLimit);

  assign status = '{rfdSync: rfdPipe[LAST], dvSync: dvPipe[LAST],
                    srcExpired: srcExp, dstExpired: dstExp, popValid: popValidQ};
  assign srcDataOut = busQ;
  assign popData    = popQ;
  assign srcTimeout = srcFlagQ;
  assign dstTimeout = dstFlagQ;

  p_src_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(srcFlagQ) |-> srcFlagQ);
  p_dst_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(dstFlagQ) |-> dstFlagQ);
  p_capture_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dstCapture |-> !popValidQ);
endmodule

// File: rtl/dhl_control.sv
module dhl_control
  import dhl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushValid,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        pushReady,
  output logic        srcDvOut,
  output logic        dstRfdOut
);
  srcState_e srcState, srcNext;
  dstState_e dstState, dstNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcState <= SRC_IDLE;
      dstState <= DST_IDLE;
    end else begin
      srcState <= srcNext;
      dstState <= dstNext;
    end
  end

  // sending half
  always_comb begin
    srcNext         = srcState;
    strobe.srcLoad  = 1'b0;
    strobe.srcDrive = 1'b0;
    strobe.srcClear = 1'b0;
    strobe.srcWait  = 1'b0;
    case (srcState)
      SRC_IDLE: if (pushValid) begin
        strobe.srcLoad = 1'b1;
        srcNext = SRC_WAIT_REQ;
      end
      SRC_WAIT_REQ: if (status.rfdSync) begin
        strobe.srcDrive = 1'b1;
        srcNext = SRC_DRIVE;
      end
      SRC_DRIVE: srcNext = SRC_VALID;
      SRC_VALID: begin
        strobe.srcWait = 1'b1;
        if (!status.rfdSync || status.srcExpired) begin
          strobe.srcClear = 1'b1;
          srcNext = SRC_IDLE;
        end
      end
      default: srcNext = SRC_IDLE;
    endcase
  end

  // receiving half
  always_comb begin
    dstNext           = dstState;
    strobe.dstCapture = 1'b0;
    strobe.dstWait    = 1'b0;
    case (dstState)
      DST_IDLE: if (!status.popValid && !status.dvSync) dstNext = DST_REQ;
      DST_REQ: if (status.dvSync) begin
        strobe.dstCapture = 1'b1;
        dstNext = DST_HOLD;
      end
      DST_HOLD: begin
        strobe.dstWait = 1'b1;
        if (!status.dvSync || status.dstExpired) dstNext = DST_IDLE;
      end
      default: dstNext = DST_IDLE;
    endcase
  end

  assign pushReady = (srcState == SRC_IDLE);
  assign srcDvOut  = (srcState == SRC_VALID);
  assign dstRfdOut = (dstState == DST_REQ);

  p_dv_after_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srcDvOut) |-> $past(status.rfdSync, 2));
  p_req_when_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    dstRfdOut |-> !status.popValid);
  p_req_after_dv_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dstRfdOut) |-> $past(!status.dvSync));
endmodule

// File: rtl/dest_handshake_link.sv
module dest_handshake_link
  import dhl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  timeoutLimit,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  output logic              pushReady,
  input  logic              srcRfdIn,
  output logic              srcDvOut,
  output logic [DATA_W-1:0] srcDataOut,
  input  logic              dstDvIn,
  input  logic [DATA_W-1:0] dstDataIn,
  output logic              dstRfdOut,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  input  logic              popTake,
  output logic              srcTimeout,
  output logic              dstTimeout
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  dhl_control ctrl_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .status(status),
    .strobe(strobe), .pushReady(pushReady), .srcDvOut(srcDvOut),
    .dstRfdOut(dstRfdOut)
  );

  dhl_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) dp_i (
    .clk(clk), .rstN(rstN), .timeoutLimit(timeoutLimit), .pushData(pushData),
    .srcRfdIn(srcRfdIn), .dstDvIn(dstDvIn), .dstDataIn(dstDataIn),
    .popTake(popTake), .strobe(strobe), .status(status),
    .srcDataOut(srcDataOut), .popData(popData),
    .srcTimeout(srcTimeout), .dstTimeout(dstTimeout)
  );

  assign popValid = status.popValid;

  p_bus_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    srcDvOut |-> $stable(srcDataOut));
  p_idle_bus_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    pushReady |-> (srcDataOut == '0));
endmodule

// File: tb/dest_handshake_link_tb_top.sv
module dest_handshake_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 16;
  localparam int LIMIT = 20;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0;
  logic [DW-1:0] pushData = '0;
  logic popTake = 1'b0;
  logic starveSrc = 1'b0;   // hold request high at sender, hide valid from receiver
  logic stuckDv = 1'b0;     // hold valid high at receiver, hide request from sender
  logic pushReady, srcDvOut, dstRfdOut, popValid, srcTimeout, dstTimeout;
  logic [DW-1:0] srcDataOut, popData;
  logic srcRfdIn, dstDvIn;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign srcRfdIn = starveSrc ? 1'b1 : (stuckDv ? 1'b0 : dstRfdOut);
  assign dstDvIn  = stuckDv ? 1'b1 : (starveSrc ? 1'b0 : srcDvOut);

  dest_handshake_link #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .timeoutLimit(CW'(LIMIT)),
    .pushValid(pushValid), .pushData(pushData), .pushReady(pushReady),
    .srcRfdIn(srcRfdIn), .srcDvOut(srcDvOut), .srcDataOut(srcDataOut),
    .dstDvIn(dstDvIn), .dstDataIn(srcDataOut), .dstRfdOut(dstRfdOut),
    .popValid(popValid), .popData(popData), .popTake(popTake),
    .srcTimeout(srcTimeout), .dstTimeout(dstTimeout)
  );

  // bench-side setup monitor for R3: bus must equal its previous value when valid rises
  logic prevDv = 1'b0;
  logic [DW-1:0] prevBus = '0;
  int setupErr = 0;
  always @(negedge clk) begin
    if (rstN && srcDvOut && !prevDv && srcDataOut != prevBus) setupErr++;
    if (rstN && srcDvOut && prevDv && srcDataOut != prevBus) setupErr++;
    prevDv  <= srcDvOut;
    prevBus <= srcDataOut;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] w);
    int t = 0;
    @(negedge clk);
    while (!pushReady && t < 200) begin @(negedge clk); t++; end
    pushValid = 1'b1;
    pushData  = w;
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic popExpect(input string req, input logic [DW-1:0] w);
    int t = 0;
    @(negedge clk);
    while (!popValid && t < 200) begin @(negedge clk); t++; end
    chk(req, popValid, 1);
    chk(req, popData, w);
    popTake = 1'b1;
    @(negedge clk);
    popTake = 1'b0;
  endtask

  task automatic testReset();
    idle(2);
    chk("R1 dv", srcDvOut, 0);
    chk("R1 req", dstRfdOut, 0);
    chk("R1 bus", srcDataOut, 0);
    chk("R1 popValid", popValid, 0);
    chk("R1 flags", {srcTimeout, dstTimeout}, 0);
    chk("R1 pushReady", pushReady, 1);
    rstN = 1'b1;
    idle(5);
    chk("R2 request raised when empty", dstRfdOut, 1);
  endtask

  task automatic testStream();
    logic [DW-1:0] w;
    for (int i = 0; i < 5; i++) begin
      w = DW'(8'h11 * (i + 1) ^ 8'h40);
      push(w);
      popExpect("R4 stream word", w);
    end
    idle(6);
    chk("R5 sender ready after transfer", pushReady, 1);
    chk("R5 valid low after transfer", srcDvOut, 0);
    chk("R3 bus zero when idle", srcDataOut, 0);
    chk("R3 setup and hold monitor", setupErr, 0);
  endtask

  task automatic testBackpressure();
    push(8'hA5);
    idle(10);
    chk("R4 first word held", popValid, 1);
    push(8'h5A);
    idle(30);
    chk("R2 no request while holding", dstRfdOut, 0);
    chk("R2 second word waits at sender", pushReady, 0);
    chk("R4 held word unchanged", popData, 8'hA5);
    popExpect("R4 order first", 8'hA5);
    popExpect("R4 order second", 8'h5A);
  endtask

  task automatic testSrcTimeout();
    int t = 0;
    idle(5);
    starveSrc = 1'b1;
    push(8'h3C);
    while (!srcDvOut && t < 50) begin @(negedge clk); t++; end
    chk("R3 valid raised", srcDvOut, 1);
    idle(10);
    chk("R6 no early sender timeout", srcTimeout, 0);
    chk("R6 valid still high", srcDvOut, 1);
    idle(20);
    chk("R6 sender timeout flag", srcTimeout, 1);
    chk("R6 valid dropped", srcDvOut, 0);
    chk("R6 sender ready again", pushReady, 1);
    starveSrc = 1'b0;
    idle(10);
    chk("R6 word discarded", popValid, 0);
    chk("R6 receiver flag untouched", dstTimeout, 0);
  endtask

  task automatic testDstTimeout();
    idle(5);
    stuckDv = 1'b1;
    idle(10);
    chk("R7 no early receiver timeout", dstTimeout, 0);
    idle(30);
    chk("R7 receiver timeout flag", dstTimeout, 1);
    chk("R7 word kept", popValid, 1);
    chk("R7 captured idle bus", popData, 0);
    popTake = 1'b1;
    @(negedge clk);
    popTake = 1'b0;
    idle(15);
    chk("R8 no request while valid high", dstRfdOut, 0);
    chk("R8 no second capture", popValid, 0);
    stuckDv = 1'b0;
    idle(8);
    chk("R2 request after valid low", dstRfdOut, 1);
    push(8'hC3);
    popExpect("R9 transfer with flags set", 8'hC3);
    chk("R9 sender flag sticky", srcTimeout, 1);
    chk("R9 receiver flag sticky", dstTimeout, 1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finishRun();
    end
  end

  initial begin
    testReset();
    testStream();
    testBackpressure();
    testSrcTimeout();
    testDstTimeout();
    finishRun();
  end
endmodule